// File: doc/BRIEF.md
# SPI Flash Configuration Register Handler

This block handles the configuration registers of a serial NOR flash slave. It sits behind an SPI shifter and works on whole bytes. The shifter presents each received byte with a one-cycle valid strobe, and a framing input shows whether chip select is asserted. The block returns a byte for the shifter to send on the next transfer. The block holds three configuration registers. The 16-bit persistent register sets the boot behaviour of the device. The 8-bit live register holds the dummy-cycle count and the execute-in-place flag. The 8-bit live extended register holds drive strength, reset/hold and the dual and quad protocol enables. Neighbouring logic decodes these fields directly from the output ports.

Inside a chip-select frame, the first byte is an opcode. A read opcode makes the following transfers return the selected register, low byte first. A write opcode is accepted only while the write-enable latch is set. The new value is committed once every data byte has arrived, and the commit clears the latch. Raising chip select abandons any partial command and discards a half-collected write.

At reset, the live registers are not loaded with fixed constants. They are built field by field from the persistent value, which comes from a parameter. The same value also selects the boot address width and the initial extended-address byte.

Top module: `spi_cfgreg_unit`

## Requirements
- R1: Opcode 0xB5 reads the persistent register: the response is bits 7:0 first, then bits 15:8, then 0x00 for every further transfer in the frame.
- R2: Opcode 0x85 reads the live register and 0x65 reads the live extended register: the response is one register byte followed by 0x00 for every further transfer.
- R3: The write opcodes 0xB1 (persistent), 0x81 (live) and 0x61 (live extended) are ignored when the write-enable latch is clear. Any data bytes that follow in the same frame change no register.
- R4: A persistent write collects two data bytes. The first byte becomes bits 7:0 and the second becomes bits 15:8. The register keeps its old value until the second byte has arrived.
- R5: A live or live extended write collects exactly one data byte and commits it. Any further bytes in the frame are ignored.
- R6: Opcode 0x06 sets the write-enable latch and 0x04 clears it. A completed configuration write also clears the latch.
- R7: Deasserting chip select aborts any partial command and discards an incomplete write, leaving the latch as it was. The first byte of the next frame is decoded as an opcode. Registers change only on a byte strobe received inside a frame.
- R8: An unrecognised opcode makes the block ignore the rest of the frame, including bytes that match valid opcodes, and the response stays 0x00.
- R9: At reset, the persistent register takes the value of parameter NV_INIT, which defaults to 0x8FFF.
- R10: At reset, the live register is set as follows: bits 1:0 = 1, bit 2 = 0, bit 3 = 1 unless persistent bits 11:9 are all ones, and bits 7:4 = persistent bits 15:12.
- R11: At reset, the live extended register is set as follows: bits 4:0 = 1, bit 5 = 0, bit 6 = persistent bit 1, and bit 7 = persistent bit 3.
- R12: At reset, the 4-byte address mode output is set when persistent bit 0 is 0. The extended-address output is 0x03 when persistent bit 1 is 0, and 0x00 otherwise. Neither output changes until the next reset.
- R13: The response byte is valid from the cycle after the strobe that selects it. It is 0x00 whenever no read is in progress, including from the cycle after chip select drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_active | input | 1 | High while chip select is asserted (frame open) |
| byte_vld | input | 1 | One-cycle strobe marking a received byte |
| byte_in | input | 8 | Received byte |
| tx_byte | output | 8 | Byte to shift out on the next transfer |
| wel | output | 1 | Write-enable latch |
| addr4_mode | output | 1 | Boot 4-byte address mode |
| ext_addr | output | 8 | Boot extended-address byte |
| persist_cfg | output | 16 | Persistent configuration register |
| live_cfg | output | 8 | Live configuration register |
| live_ext_cfg | output | 8 | Live extended configuration register |

## Verification
Each byte is driven on a falling clock edge and captured on the next rising edge. Every result is due one rising edge after the strobe that causes it. A committed register value, a latch change and the next response byte all become visible together. The bench therefore checks them on the falling edge that ends each strobe. A dropped chip select takes effect one edge later, so the bench holds it low for one full cycle before it reopens a frame and checks the outcome.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam int CFG_W  = 16;
    localparam int IDX_W  = 2;

    localparam logic [BYTE_W-1:0] OP_PERS_RD = 8'hB5;
    localparam logic [BYTE_W-1:0] OP_PERS_WR = 8'hB1;
    localparam logic [BYTE_W-1:0] OP_LIVE_RD = 8'h85;
    localparam logic [BYTE_W-1:0] OP_LIVE_WR = 8'h81;
    localparam logic [BYTE_W-1:0] OP_LEXT_RD = 8'h65;
    localparam logic [BYTE_W-1:0] OP_LEXT_WR = 8'h61;
    localparam logic [BYTE_W-1:0] OP_WEN     = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WDIS    = 8'h04;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_PERS = 2'd1,
        TGT_LIVE = 2'd2,
        TGT_LEXT = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        ST_OPCODE  = 2'd0,
        ST_COLLECT = 2'd1,
        ST_READOUT = 2'd2,
        ST_DRAIN   = 2'd3
    } dec_state_e;

    typedef struct packed {
        logic               valid;
        tgt_e               tgt;
        logic [CFG_W-1:0]   data;
    } commit_t;

    // Number of bytes a register occupies on the wire.
    function automatic logic [IDX_W-1:0] tgt_bytes(input tgt_e t);
        case (t)
            TGT_PERS: tgt_bytes = 2'd2;
            TGT_LIVE: tgt_bytes = 2'd1;
            TGT_LEXT: tgt_bytes = 2'd1;
            default:  tgt_bytes = 2'd1;
        endcase
    endfunction

    // Live register image built from the persistent value.
    function automatic logic [BYTE_W-1:0] boot_live(input logic [CFG_W-1:0] p);
        logic [BYTE_W-1:0] v;
        v        = '0;
        v[1:0]   = 2'b11;
        v[3]     = (p[11:9] != 3'b111);
        v[7:4]   = p[15:12];
        return v;
    endfunction

    // Live extended register image built from the persistent value.
    function automatic logic [BYTE_W-1:0] boot_live_ext(input logic [CFG_W-1:0] p);
        logic [BYTE_W-1:0] v;
        v        = '0;
        v[4:0]   = 5'b11111;
        v[6]     = p[1];
        v[7]     = p[3];
        return v;
    endfunction

    function automatic logic [BYTE_W-1:0] boot_ext_addr(input logic [CFG_W-1:0] p);
        return p[1] ? 8'h00 : 8'h03;
    endfunction

endpackage

// File: rtl/cfg_decoder.sv
module cfg_decoder
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_active,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              wel,
    output commit_t           commit,
    output logic              wel_set,
    output logic              wel_clr,
    output logic              rd_active,
    output tgt_e              rd_tgt,
    output logic [IDX_W-1:0]  rd_idx
);

    dec_state_e        state_q, state_d;
    tgt_e              tgt_q, tgt_d;
    logic [IDX_W-1:0]  cnt_q, cnt_d;
    logic [BYTE_W-1:0] lo_q, lo_d;

    // Opens a write when the latch allows it, otherwise drains the frame.
    function automatic dec_state_e write_entry(input logic en);
        return en ? ST_COLLECT : ST_DRAIN;
    endfunction

    always_comb begin
        state_d = state_q;
        tgt_d   = tgt_q;
        cnt_d   = cnt_q;
        lo_d    = lo_q;
        commit  = '0;
        wel_set = 1'b0;
        wel_clr = 1'b0;
        if (!cs_active) begin
            state_d = ST_OPCODE;
            tgt_d   = TGT_NONE;
            cnt_d   = '0;
        end else if (byte_vld) begin
            case (state_q)
                ST_OPCODE: begin
                    cnt_d = '0;
                    case (byte_in)
                        OP_PERS_RD: begin state_d = ST_READOUT; tgt_d = TGT_PERS; end
                        OP_LIVE_RD: begin state_d = ST_READOUT; tgt_d = TGT_LIVE; end
                        OP_LEXT_RD: begin state_d = ST_READOUT; tgt_d = TGT_LEXT; end
                        OP_PERS_WR: begin state_d = write_entry(wel); tgt_d = TGT_PERS; end
                        OP_LIVE_WR: begin state_d = write_entry(wel); tgt_d = TGT_LIVE; end
                        OP_LEXT_WR: begin state_d = write_entry(wel); tgt_d = TGT_LEXT; end
                        OP_WEN: begin
                            wel_set = 1'b1;
                            state_d = ST_DRAIN;
                        end
                        OP_WDIS: begin
                            wel_clr = 1'b1;
                            state_d = ST_DRAIN;
                        end
                        default: state_d = ST_DRAIN;
                    endcase
                end
                ST_COLLECT: begin
                    if (cnt_q == tgt_bytes(tgt_q) - 2'd1) begin
                        commit.valid = 1'b1;
                        commit.tgt   = tgt_q;
                        commit.data  = (tgt_q == TGT_PERS) ? {byte_in, lo_q}
                                                           : {8'h00, byte_in};
                        state_d      = ST_DRAIN;
                    end else begin
                        lo_d  = byte_in;
                        cnt_d = cnt_q + 2'd1;
                    end
                end
                ST_READOUT: begin
                    if (cnt_q != '1) cnt_d = cnt_q + 2'd1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OPCODE;
            tgt_q   <= TGT_NONE;
            cnt_q   <= '0;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
            cnt_q   <= cnt_d;
            lo_q    <= lo_d;
        end
    end

    assign rd_active = (state_q == ST_READOUT);
    assign rd_tgt    = tgt_q;
    assign rd_idx    = cnt_q;

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import spi_cfg_pkg::*;
#(
    parameter logic [CFG_W-1:0] NV_INIT = 16'h8FFF
) (
    input  logic              clk,
    input  logic              rst,
    input  commit_t           commit,
    input  logic              wel_set,
    input  logic              wel_clr,
    output logic [CFG_W-1:0]  persist_q,
    output logic [BYTE_W-1:0] live_q,
    output logic [BYTE_W-1:0] lext_q,
    output logic              wel_q,
    output logic              addr4_q,
    output logic [BYTE_W-1:0] ext_addr_q
);

    localparam logic [BYTE_W-1:0] LIVE_BOOT = boot_live(NV_INIT);
    localparam logic [BYTE_W-1:0] LEXT_BOOT = boot_live_ext(NV_INIT);
    localparam logic [BYTE_W-1:0] EXTA_BOOT = boot_ext_addr(NV_INIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            persist_q  <= NV_INIT;
            live_q     <= LIVE_BOOT;
            lext_q     <= LEXT_BOOT;
            addr4_q    <= ~NV_INIT[0];
            ext_addr_q <= EXTA_BOOT;
        end else if (commit.valid) begin
            case (commit.tgt)
                TGT_PERS: persist_q <= commit.data;
                TGT_LIVE: live_q    <= commit.data[BYTE_W-1:0];
                TGT_LEXT: lext_q    <= commit.data[BYTE_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              wel_q <= 1'b0;
        else if (commit.valid) wel_q <= 1'b0;
        else if (wel_clr)     wel_q <= 1'b0;
        else if (wel_set)     wel_q <= 1'b1;
    end

endmodule

// File: rtl/cfg_txsel.sv
module cfg_txsel
    import spi_cfg_pkg::*;
(
    input  logic              rd_active,
    input  tgt_e              rd_tgt,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [CFG_W-1:0]  persist_q,
    input  logic [BYTE_W-1:0] live_q,
    input  logic [BYTE_W-1:0] lext_q,
    output logic [BYTE_W-1:0] tx_byte
);

    always_comb begin
        tx_byte = '0;
        if (rd_active) begin
            case (rd_tgt)
                TGT_PERS: begin
                    if (rd_idx == 2'd0)      tx_byte = persist_q[7:0];
                    else if (rd_idx == 2'd1) tx_byte = persist_q[15:8];
                end
                TGT_LIVE: if (rd_idx == 2'd0) tx_byte = live_q;
                TGT_LEXT: if (rd_idx == 2'd0) tx_byte = lext_q;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/spi_cfgreg_unit.sv
module spi_cfgreg_unit
    import spi_cfg_pkg::*;
#(
    parameter logic [15:0] NV_INIT = 16'h8FFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_active,
    input  logic        byte_vld,
    input  logic [7:0]  byte_in,
    output logic [7:0]  tx_byte,
    output logic        wel,
    output logic        addr4_mode,
    output logic [7:0]  ext_addr,
    output logic [15:0] persist_cfg,
    output logic [7:0]  live_cfg,
    output logic [7:0]  live_ext_cfg
);

    commit_t          commit;
    logic             wel_set, wel_clr, rd_active;
    tgt_e             rd_tgt;
    logic [IDX_W-1:0] rd_idx;

    cfg_decoder u_dec (
        .clk       (clk),
        .rst       (rst),
        .cs_active (cs_active),
        .byte_vld  (byte_vld),
        .byte_in   (byte_in),
        .wel       (wel),
        .commit    (commit),
        .wel_set   (wel_set),
        .wel_clr   (wel_clr),
        .rd_active (rd_active),
        .rd_tgt    (rd_tgt),
        .rd_idx    (rd_idx)
    );

    cfg_regbank #(.NV_INIT(NV_INIT)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .wel_set    (wel_set),
        .wel_clr    (wel_clr),
        .persist_q  (persist_cfg),
        .live_q     (live_cfg),
        .lext_q     (live_ext_cfg),
        .wel_q      (wel),
        .addr4_q    (addr4_mode),
        .ext_addr_q (ext_addr)
    );

    cfg_txsel u_tx (
        .rd_active (rd_active),
        .rd_tgt    (rd_tgt),
        .rd_idx    (rd_idx),
        .persist_q (persist_cfg),
        .live_q    (live_cfg),
        .lext_q    (live_ext_cfg),
        .tx_byte   (tx_byte)
    );

endmodule

// File: rtl/spi_cfgreg_unit_chk.sv
module spi_cfgreg_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        cs_active,
    input logic        byte_vld,
    input logic [7:0]  byte_in,
    input logic [7:0]  tx_byte,
    input logic        wel,
    input logic        addr4_mode,
    input logic [7:0]  ext_addr,
    input logic [15:0] persist_cfg,
    input logic [7:0]  live_cfg,
    input logic [7:0]  live_ext_cfg
);

    // R13: the response is 0x00 once the frame has closed
    a_r13_idle_tx_zero: assert property (@(posedge clk) disable iff (rst)
        !cs_active |=> tx_byte == 8'h00);

    // R3: no register moves while the latch is clear
    a_r3_gated_write: assert property (@(posedge clk) disable iff (rst)
        !wel |=> ($stable(persist_cfg) && $stable(live_cfg) && $stable(live_ext_cfg)));

    // R7: registers move only on an in-frame byte strobe
    a_r7_no_change_outside: assert property (@(posedge clk) disable iff (rst)
        (!cs_active || !byte_vld) |=> ($stable(persist_cfg) && $stable(live_cfg)
                                       && $stable(live_ext_cfg) && $stable(wel)));

    // R6: the latch is set only by the set opcode
    a_r6_wel_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> ($past(byte_vld) && $past(cs_active) && $past(byte_in) == 8'h06));

    // R6: a committed write leaves the latch clear
    a_r6_commit_clears: assert property (@(posedge clk) disable iff (rst)
        !$stable(persist_cfg) |-> !wel);

    // R12: boot address outputs hold until the next reset
    a_r12_boot_hold: assert property (@(posedge clk) disable iff (rst)
        cs_active || !cs_active |=> ($stable(addr4_mode) && $stable(ext_addr)));

endmodule

bind spi_cfgreg_unit spi_cfgreg_unit_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cs_active    (cs_active),
    .byte_vld     (byte_vld),
    .byte_in      (byte_in),
    .tx_byte      (tx_byte),
    .wel          (wel),
    .addr4_mode   (addr4_mode),
    .ext_addr     (ext_addr),
    .persist_cfg  (persist_cfg),
    .live_cfg     (live_cfg),
    .live_ext_cfg (live_ext_cfg)
);

// File: tb/tb_spi_cfgreg_unit.sv
`timescale 1ns/1ps
module tb_spi_cfgreg_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_active = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic [7:0]  tx_byte, ext_addr, live_cfg, live_ext_cfg;
    logic        wel, addr4_mode;
    logic [15:0] persist_cfg;

    logic [7:0]  tx2, ext2, live2, lext2;
    logic        wel2, a4_2;
    logic [15:0] pers2;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [15:0] m_pers;
    logic [7:0]  m_live, m_lext;
    logic        m_wel;

    always #5 clk = ~clk;

    spi_cfgreg_unit dut (
        .clk(clk), .rst(rst), .cs_active(cs_active), .byte_vld(byte_vld),
        .byte_in(byte_in), .tx_byte(tx_byte), .wel(wel), .addr4_mode(addr4_mode),
        .ext_addr(ext_addr), .persist_cfg(persist_cfg), .live_cfg(live_cfg),
        .live_ext_cfg(live_ext_cfg));

    spi_cfgreg_unit #(.NV_INIT(16'h5A94)) dut2 (
        .clk(clk), .rst(rst), .cs_active(cs_active), .byte_vld(byte_vld),
        .byte_in(byte_in), .tx_byte(tx2), .wel(wel2), .addr4_mode(a4_2),
        .ext_addr(ext2), .persist_cfg(pers2), .live_cfg(live2),
        .live_ext_cfg(lext2));

    function automatic logic [7:0] exp_live(input logic [15:0] p);
        logic [7:0] r;
        r = {p[15:12], 4'b0011};
        if (p[11:9] != 3'b111) r = r | 8'h08;
        return r;
    endfunction

    function automatic logic [7:0] exp_lext(input logic [15:0] p);
        return 8'h1F | (p[1] ? 8'h40 : 8'h00) | (p[3] ? 8'h80 : 8'h00);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one byte starting at a falling edge; returns at the next falling edge.
    task automatic send(input logic [7:0] b);
        byte_vld = 1'b1;
        byte_in  = b;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic open_frame();
        cs_active = 1'b1;
    endtask

    task automatic close_frame();
        cs_active = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_regs(input string req);
        check({req, " pers"}, persist_cfg, m_pers);
        check({req, " live"}, {8'h00, live_cfg}, {8'h00, m_live});
        check({req, " lext"}, {8'h00, live_ext_cfg}, {8'h00, m_lext});
        check({req, " wel"}, {15'h0, wel}, {15'h0, m_wel});
    endtask

    task automatic do_read(input logic [7:0] op, input int extra);
        logic [7:0] b0, b1;
        int nb;
        case (op)
            8'hB5: begin b0 = m_pers[7:0]; b1 = m_pers[15:8]; nb = 2; end
            8'h85: begin b0 = m_live; b1 = 8'h00; nb = 1; end
            default: begin b0 = m_lext; b1 = 8'h00; nb = 1; end
        endcase
        open_frame();
        send(op);
        check(op == 8'hB5 ? "R1 first byte" : "R2 reg byte", {8'h00, tx_byte}, {8'h00, b0});
        for (int i = 1; i <= extra; i++) begin
            send($urandom_range(0, 255));
            if (i == 1 && nb == 2) check("R1 second byte", {8'h00, tx_byte}, {8'h00, b1});
            else check("R2 pad byte", {8'h00, tx_byte}, 16'h0000);
        end
        close_frame();
        check("R13 tx after close", {8'h00, tx_byte}, 16'h0000);
    endtask

    task automatic do_write(input logic [7:0] op, input logic [15:0] val, input int nsend);
        int need;
        need = (op == 8'hB1) ? 2 : 1;
        open_frame();
        send(op);
        for (int i = 0; i < nsend; i++) send(i == 0 ? val[7:0] : val[15:8]);
        close_frame();
        if (m_wel && nsend >= need) begin
            case (op)
                8'hB1: m_pers = val;
                8'h81: m_live = val[7:0];
                default: m_lext = val[7:0];
            endcase
            m_wel = 1'b0;
        end
        check_regs(m_wel || nsend < need ? "R7 R3 write" : "R4 R5 write");
    endtask

    task automatic latch_cmd(input logic [7:0] op);
        open_frame();
        send(op);
        close_frame();
        m_wel = (op == 8'h06);
        check(op == 8'h06 ? "R6 set" : "R6 clear", {15'h0, wel}, {15'h0, m_wel});
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] u;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        m_pers = 16'h8FFF; m_live = exp_live(16'h8FFF); m_lext = exp_lext(16'h8FFF); m_wel = 0;
        check("R9 pers reset", persist_cfg, 16'h8FFF);
        check("R10 live boot", {8'h00, live_cfg}, 16'h0083);
        check("R11 lext boot", {8'h00, live_ext_cfg}, 16'h00DF);
        check("R12 addr4", {15'h0, addr4_mode}, 16'h0000);
        check("R12 ext_addr", {8'h00, ext_addr}, 16'h0000);
        check("R13 tx idle", {8'h00, tx_byte}, 16'h0000);
        check("R6 wel reset", {15'h0, wel}, 16'h0000);
        check("R9 pers param", pers2, 16'h5A94);
        check("R10 live param", {8'h00, live2}, {8'h00, exp_live(16'h5A94)});
        check("R11 lext param", {8'h00, lext2}, {8'h00, exp_lext(16'h5A94)});
        check("R12 addr4 param", {15'h0, a4_2}, 16'h0001);
        check("R12 ext_addr param", {8'h00, ext2}, 16'h0003);

        // Reads
        do_read(8'hB5, 3);
        do_read(8'h85, 2);
        do_read(8'h65, 2);

        // R3: write without latch
        do_write(8'h81, 16'h0055, 1);
        do_write(8'hB1, 16'h1111, 2);

        // R6 set/clear
        latch_cmd(8'h06);
        latch_cmd(8'h04);
        latch_cmd(8'h06);

        // R4: persistent write takes effect only after the second byte
        open_frame();
        send(8'hB1);
        send(8'h34);
        check("R4 after first byte", persist_cfg, m_pers);
        send(8'h12);
        check("R4 after second byte", persist_cfg, 16'h1234);
        check("R6 commit clears", {15'h0, wel}, 16'h0000);
        close_frame();
        m_pers = 16'h1234; m_wel = 0;

        // R5: extra bytes after a one-byte write are ignored
        latch_cmd(8'h06);
        open_frame();
        send(8'h61); send(8'hA5); send(8'h3C);
        close_frame();
        m_lext = 8'hA5; m_wel = 0;
        check("R5 lext one byte", {8'h00, live_ext_cfg}, 16'h00A5);

        // R7: abort after one persistent byte
        latch_cmd(8'h06);
        do_write(8'hB1, 16'hBEEF, 1);
        check("R7 latch kept", {15'h0, wel}, 16'h0001);
        do_read(8'h85, 1);

        // R8: unknown opcode then valid opcodes in the same frame
        open_frame();
        send(8'h9F);
        send(8'hB5);
        check("R8 no read", {8'h00, tx_byte}, 16'h0000);
        send(8'h81);
        send(8'h77);
        close_frame();
        check("R8 live kept", {8'h00, live_cfg}, {8'h00, m_live});
        check("R8 latch kept", {15'h0, wel}, 16'h0001);

        // Random mix
        for (int t = 0; t < 400; t++) begin
            case ($urandom_range(0, 6))
                0: do_read(8'hB5, $urandom_range(0, 3));
                1: do_read(($urandom_range(0, 1) != 0) ? 8'h85 : 8'h65, $urandom_range(0, 2));
                2: do_write(8'hB1, 16'($urandom), $urandom_range(0, 2));
                3: do_write(($urandom_range(0, 1) != 0) ? 8'h81 : 8'h61, 16'($urandom), $urandom_range(0, 1));
                4: latch_cmd(8'h06);
                5: latch_cmd(8'h04);
                default: begin
                    u = 8'($urandom);
                    if (u == 8'hB5 || u == 8'hB1 || u == 8'h85 || u == 8'h81 ||
                        u == 8'h65 || u == 8'h61 || u == 8'h06 || u == 8'h04) u = 8'hFF;
                    open_frame();
                    send(u);
                    send(8'h06);
                    check("R8 unknown tx", {8'h00, tx_byte}, 16'h0000);
                    close_frame();
                    check_regs("R8 unknown regs");
                end
            endcase
        end
        check("R12 addr4 hold", {15'h0, addr4_mode}, 16'h0000);
        check("R12 ext_addr hold", {8'h00, ext_addr}, 16'h0000);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule